// File: doc/BRIEF.md
# 40-bit Timestamp Counter with Split-Word Capture

This block keeps a free-running 40-bit time base for a processor subsystem. The count advances by one on every clock edge where an external tick strobe is high and the enable bit is set. The tick comes from a slow divided clock of about 983 kHz. The block raises no interrupt and gives no wrap indication. When it overflows, it simply rolls over to zero.

Software reads the value through two 32-bit registers on a simple byte-addressed register port. Reading the low-word register (offset 0x60) returns count bits 31:0. In the same cycle, it copies count bits 39:32 into a holding byte. A later read of the high register (offset 0x64) returns that held byte, so the two halves always belong to one instant even when a carry crosses bit 32 between the two reads. The high register also carries the enable bit, which software sets or clears by writing that register.

The reset value of the counter is a parameter. Its default is zero.

Top module: `tstamp40`

## Requirements
- R1: After reset, the count equals the reset-value parameter (default zero), the enable bit is 0 and the holding byte is 0.
- R2: A write to offset 0x64 loads the enable bit from write-data bit 8. The other write-data bits have no effect.
- R3: When enabled, the count rises by exactly one at each clock edge where the tick is high. When disabled, or when the tick is low, the count holds its value.
- R4: A read at offset 0x60 returns count bits 31:0 on the read data in the same cycle.
- R5: A read at offset 0x60 loads the holding byte with count bits 39:32 as they were in that cycle. This is before any tick that lands on the same edge.
- R6: A read at offset 0x64 returns the holding byte in bits 7:0, the enable bit in bit 8 and zeros in bits 31:9. The holding byte changes only on a low-word read.
- R7: From all ones, one more tick brings the count to zero. There is no other effect.
- R8: Writes to offset 0x60 or to any unmapped offset change nothing. Reads at unmapped offsets return zero.
- R9: The read data is zero in any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base advance strobe, one clock wide per tick |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as rd_en |

## Verification
The bench elaborates the block with a reset value 32 ticks below the wrap point. The pre-wrap stretch exercises the carry across bit 32 and the full roll-over together. In a directed sequence, a low-word read coincides with the tick that carries. This separates a capture of the pre-tick high byte from a capture of the post-tick one.

Repeated high reads without a low read in between show whether the holding byte is refreshed by the wrong access. Writes to the read-only offset, to unmapped offsets, and with bit 8 clear but all other bits set show whether the enable decode is too loose.

A long random phase mixes ticks, reads at all offsets and occasional enable toggles. A bench model checks it, which separates counting from holding under every combination of enable and tick.

// File: rtl/tstamp40_pkg.sv
package tstamp40_pkg;

  // One-hot strobes produced by the register decode
  typedef struct packed {
    logic lo_rd;
    logic hi_rd;
    logic hi_wr;
  } acc_t;

endpackage

// File: rtl/tstamp40_decode.sv
module tstamp40_decode
  import tstamp40_pkg::*;
#(
  parameter int              ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_OFF = 8'h60,
  parameter logic [ADDR_W-1:0] HI_OFF = 8'h64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);

  logic hit_lo;
  logic hit_hi;

  assign hit_lo = (addr == LO_OFF);
  assign hit_hi = (addr == HI_OFF);

  // The low word is read-only: no write strobe is decoded for it
  always_comb begin
    acc       = '0;
    acc.lo_rd = rd_en & hit_lo;
    acc.hi_rd = rd_en & hit_hi;
    acc.hi_wr = wr_en & hit_hi;
  end

  // R8
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_lo && !hit_hi) |-> (acc == '0));

  // R8
  lo_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && hit_lo) |-> (acc == '0));

endmodule

// File: rtl/tstamp40_count.sv
module tstamp40_count #(
  parameter int             CNT_W   = 40,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt
);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  logic step_ev;
  logic at_top;

  assign step_ev = run & tick_i;
  assign at_top  = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= RST_VAL;
    else if (step_ev) cnt <= bump(cnt);
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_ev |=> (cnt == $past(cnt)));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !at_top) |=> (cnt > $past(cnt)) && ((cnt - $past(cnt)) == CNT_W'(1)));

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && at_top) |=> (cnt == '0));

endmodule

// File: rtl/tstamp40_ctrl.sv
module tstamp40_ctrl #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              en_bit,
  input  logic              snap,
  input  logic [HOLD_W-1:0] cnt_hi,
  output logic              run,
  output logic [HOLD_W-1:0] hold
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run <= 1'b0;
    else if (en_wr) run <= en_bit;
  end

  // Capture takes the pre-edge upper byte, matching the low word read now
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold <= '0;
    else if (snap) hold <= cnt_hi;
  end

  // R5
  snap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (hold == $past(cnt_hi)));

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(hold));

  // R2
  run_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (run == $past(en_bit)));

  // R2
  run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(run));

endmodule

// File: rtl/tstamp40.sv
module tstamp40
  import tstamp40_pkg::*;
#(
  parameter int                    CNT_W   = 40,
  parameter int                    DATA_W  = 32,
  parameter int                    ADDR_W  = 8,
  parameter int                    EN_BIT  = 8,
  parameter logic [ADDR_W-1:0]     LO_OFF  = 8'h60,
  parameter logic [ADDR_W-1:0]     HI_OFF  = 8'h64,
  parameter logic [CNT_W-1:0]      RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int HOLD_W = CNT_W - DATA_W;

  acc_t              acc;
  logic              run;
  logic [CNT_W-1:0]  cnt;
  logic [HOLD_W-1:0] hold;
  logic              unused_wdata;

  function automatic logic [DATA_W-1:0] hi_word(input logic e,
                                                input logic [HOLD_W-1:0] h);
    logic [DATA_W-1:0] r;
    r             = '0;
    r[HOLD_W-1:0] = h;
    r[EN_BIT]     = e;
    return r;
  endfunction

  assign unused_wdata = ^{wdata[DATA_W-1:EN_BIT+1], wdata[EN_BIT-1:0]};

  tstamp40_decode #(
    .ADDR_W (ADDR_W),
    .LO_OFF (LO_OFF),
    .HI_OFF (HI_OFF)
  ) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .addr  (addr),
    .acc   (acc)
  );

  tstamp40_count #(
    .CNT_W   (CNT_W),
    .RST_VAL (RST_VAL)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .tick_i (tick_i),
    .cnt    (cnt)
  );

  tstamp40_ctrl #(
    .HOLD_W (HOLD_W)
  ) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_wr  (acc.hi_wr),
    .en_bit (wdata[EN_BIT]),
    .snap   (acc.lo_rd),
    .cnt_hi (cnt[CNT_W-1:DATA_W]),
    .run    (run),
    .hold   (hold)
  );

  always_comb begin
    rdata = '0;
    if (acc.lo_rd)      rdata = cnt[DATA_W-1:0];
    else if (acc.hi_rd) rdata = hi_word(run, hold);
  end

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));

  // R6
  hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc.hi_rd |-> (rdata[DATA_W-1:EN_BIT+1] == '0));

  // R4
  lo_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.lo_rd && run && tick_i) |=> (cnt[DATA_W-1:0] == $past(rdata) + DATA_W'(1)));

endmodule

// File: tb/tstamp40_test.sv
module tstamp40_test;

  localparam logic [39:0] RV    = 40'hFF_FFFF_FFE0;
  localparam logic [7:0]  A_LO  = 8'h60;
  localparam logic [7:0]  A_HI  = 8'h64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i, rd_en, wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [39:0] m_cnt;
  logic        m_en;
  logic [7:0]  m_hold;

  always #2 clk = ~clk;

  tstamp40 #(.RST_VAL(RV)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [31:0] want(input logic r, input logic [7:0] a);
    if (!r)        return 32'h0;
    if (a == A_LO) return m_cnt[31:0];
    if (a == A_HI) return {23'h0, m_en, m_hold};
    return 32'h0;
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata=%h expected=%h (cnt model %h)", req, got, exp, m_cnt);
    end
  endtask

  // One bus cycle: drive at the falling edge, sample before the rising edge,
  // then advance the model with the pre-edge values.
  task automatic step(input logic t, input logic r, input logic w,
                      input logic [7:0] a, input logic [31:0] d, input string req);
    logic        en_old;
    logic [39:0] c_old;
    tick_i = t; rd_en = r; wr_en = w; addr = a; wdata = d;
    #1;
    check(rdata, want(r, a), req);
    en_old = m_en;
    c_old  = m_cnt;
    @(posedge clk);
    if (r && a == A_LO) m_hold = c_old[39:32];
    if (w && a == A_HI) m_en = d[8];
    if (en_old && t)    m_cnt = c_old + 40'd1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0040));
    rst_n = 1'b0; tick_i = 0; rd_en = 0; wr_en = 0; addr = 0; wdata = 0;
    m_cnt = RV; m_en = 0; m_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state seen through both registers
    step(0, 1, 0, A_HI, 0, "R1");
    step(0, 1, 0, A_LO, 0, "R1");
    // R3: ticks while disabled leave the count
    repeat (4) step(1, 0, 0, A_LO, 0, "R9");
    step(0, 1, 0, A_LO, 0, "R3");
    // R8: write to read-only low word and to unmapped offset
    step(0, 0, 1, A_LO, 32'h100, "R8");
    step(0, 0, 1, 8'h68, 32'h100, "R8");
    step(0, 1, 0, A_HI, 0, "R8");
    step(0, 1, 0, 8'h68, 0, "R8");
    step(0, 1, 0, 8'h00, 0, "R8");
    // R2: all bits but bit 8 set keeps the counter off
    step(0, 0, 1, A_HI, 32'hFFFF_FEFF, "R2");
    step(0, 1, 0, A_HI, 0, "R2");
    step(0, 0, 1, A_HI, 32'h0000_0100, "R2");
    step(0, 1, 0, A_HI, 0, "R2");
    // R3: advance to all ones (one tick per cycle, some gaps)
    repeat (31) step(1, 0, 0, 8'h00, 0, "R3");
    step(0, 0, 0, 8'h00, 0, "R3");
    step(0, 1, 0, A_LO, 0, "R4");
    // R5/R7: low read on the wrapping tick captures the pre-tick byte
    step(1, 1, 0, A_LO, 0, "R5");
    step(0, 1, 0, A_HI, 0, "R5");
    step(0, 1, 0, A_LO, 0, "R7");
    step(0, 1, 0, A_HI, 0, "R6");
    step(1, 1, 0, A_HI, 0, "R6");
    step(0, 1, 0, A_LO, 0, "R5");
    step(0, 1, 0, A_HI, 0, "R6");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  k;
      logic [7:0]  a;
      logic        t;
      k = 4'($urandom_range(0, 15));
      t = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 4))
        0, 1:    a = A_LO;
        2:       a = A_HI;
        3:       a = 8'h68;
        default: a = 8'($urandom);
      endcase
      if (k == 0)
        step(t, 0, 1, A_HI, ($urandom_range(0, 7) != 0) ? 32'h100 : $urandom, "R2");
      else if (k < 9)
        step(t, 1, 0, a, 0, (a == A_LO) ? "R4" : (a == A_HI) ? "R6" : "R8");
      else
        step(t, 0, 0, a, 0, "R9");
    end

    // R3: disabled again, ticks do nothing
    step(0, 0, 1, A_HI, 32'h0, "R2");
    repeat (5) step(1, 0, 0, A_LO, 0, "R9");
    step(1, 1, 0, A_LO, 0, "R3");
    step(0, 1, 0, A_LO, 0, "R3");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule